// File: doc/BRIEF.md
# Per-Branch Two-Level History Direction Predictor

This block predicts whether a conditional branch will be taken from the recent behaviour of that same branch. Each branch keeps its own short history of outcomes. A slice of the branch address selects one history register in a first-level table. The pattern in that register then selects a 2-bit saturating counter in a shared second-level table. The counter's upper bit is the prediction.

The fetch side presents a branch address on the lookup port. In the same cycle it receives the prediction and the history pattern that produced it. It then shifts the chosen outcome into that branch's history through the speculative port, without waiting for the branch to resolve.

When the branch retires, the commit port trains the counter. It carries the resolved outcome and the history snapshot taken at lookup. The counter that made the prediction is therefore the one trained, even if later branches have already moved the history on.

Top module: `lhist_predictor`

## Requirements
- R1: After reset every history register reads 0 and every counter holds 01 (weakly not-taken), so every lookup returns history 0 and a not-taken prediction.
- R2: The first-level entry is selected by address bits [IDX_LSB +: IDX_W] (bits 11:2 by default). Addresses that differ only outside that slice share an entry. Addresses that differ inside it use separate entries.
- R3: Lookup is combinational. `pred_hist_o` is the current history of the selected entry. `pred_taken_o` is 1 exactly when the counter indexed by that history is 2 or 3.
- R4: A clock edge with `spec_valid_i` high replaces the entry selected by `spec_pc_i` with the old value shifted left by one. `spec_taken_i` enters at bit 0 and the old top bit is lost. No other entry changes.
- R5: Counters change only on a commit, and histories change only on a speculative update. A speculative update leaves every counter unchanged, and a commit leaves every history unchanged.
- R6: A clock edge with `commit_valid_i` high moves the counter indexed by `commit_hist_i` by one step. It moves up when `commit_taken_i` is 1, saturating at 3, and down when it is 0, saturating at 0. The other counters keep their values.
- R7: A commit trains the counter named by `commit_hist_i`, not the counter named by any branch's current history.
- R8: An update in a cycle is not seen by a lookup in that same cycle. The lookup returns the pre-update history and counter, and the new value is visible from the next cycle.
- R9: A speculative update and a commit in the same cycle both take effect, each as if it were alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_pc_i | input | PC_W | Address of the branch being predicted |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| pred_hist_o | output | HIST_W | History pattern used for the prediction |
| spec_valid_i | input | 1 | Shift an outcome into a history register |
| spec_pc_i | input | PC_W | Address whose history is shifted |
| spec_taken_i | input | 1 | Outcome shifted in |
| commit_valid_i | input | 1 | Train a counter |
| commit_hist_i | input | HIST_W | History snapshot captured at lookup |
| commit_taken_i | input | 1 | Resolved outcome |

## Verification
The bench goes after counters held at the limits 0 and 3. A design that wrapped there would flip its prediction after a long run of one outcome. It also sets up commits whose snapshot differs from the live history. A design that indexed training by the live history would move the wrong counter, and that shows at a later lookup. Address aliasing above and below the index slice is tested, and so are same-cycle update-and-lookup pairs. A design with a bypass, or with the shift in the wrong direction, returns a history that disagrees with the bench's arithmetic model.

// File: rtl/lhist_pkg.sv
package lhist_pkg;
  typedef logic [1:0] ctr_t;
  localparam ctr_t CTR_RST = 2'b01;
  localparam ctr_t CTR_MAX = 2'b11;
  localparam ctr_t CTR_MIN = 2'b00;

  function automatic ctr_t ctr_step(input ctr_t cur, input logic up);
    if (up) return (cur == CTR_MAX) ? CTR_MAX : cur + 2'd1;
    else    return (cur == CTR_MIN) ? CTR_MIN : cur - 2'd1;
  endfunction
endpackage

// File: rtl/lhist_sat_ctr.sv
module lhist_sat_ctr
  import lhist_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic upd_i,
  input  logic up_i,
  output ctr_t ctr_o
);
  ctr_t ctr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ctr_q <= CTR_RST;
    else if (upd_i) ctr_q <= ctr_step(ctr_q, up_i);
  end

  assign ctr_o = ctr_q;

  a_r6_sat_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && up_i && ctr_q == CTR_MAX) |=> ctr_q == CTR_MAX);
  a_r6_sat_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !up_i && ctr_q == CTR_MIN) |=> ctr_q == CTR_MIN);
  a_r6_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && up_i) |=> ctr_q >= $past(ctr_q));
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(ctr_q));
endmodule

// File: rtl/lhist_hist_table.sv
module lhist_hist_table #(
  parameter int IDX_W  = 10,
  parameter int HIST_W = 4,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [HIST_W-1:0] rd_hist_o,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              taken_i
);
  logic [HIST_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[wr_idx_i] <= {mem_q[wr_idx_i][HIST_W-2:0], taken_i};
    end
  end

  assign rd_hist_o = mem_q[rd_idx_i];

  a_r4_newest_lsb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(wr_idx_i)][0] == $past(taken_i));
  a_r4_shift_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(wr_idx_i)][HIST_W-1:1] == $past(mem_q[wr_idx_i][HIST_W-2:0]));
  a_r5_hist_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> mem_q[$past(rd_idx_i)] == $past(mem_q[rd_idx_i]));
endmodule

// File: rtl/lhist_pattern_table.sv
module lhist_pattern_table
  import lhist_pkg::*;
#(
  parameter int HIST_W = 4,
  localparam int NCTR  = 1 << HIST_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HIST_W-1:0] rd_hist_i,
  output logic              rd_taken_o,
  input  logic              upd_i,
  input  logic [HIST_W-1:0] upd_hist_i,
  input  logic              upd_taken_i
);
  ctr_t ctr_vec [NCTR];

  for (genvar g = 0; g < NCTR; g++) begin : g_ctr
    lhist_sat_ctr u_ctr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .upd_i (upd_i && (upd_hist_i == HIST_W'(g))),
      .up_i  (upd_taken_i),
      .ctr_o (ctr_vec[g])
    );
  end

  assign rd_taken_o = ctr_vec[rd_hist_i][1];
endmodule

// File: rtl/lhist_predictor.sv
module lhist_predictor #(
  parameter int PC_W    = 32,
  parameter int IDX_LSB = 2,
  parameter int IDX_W   = 10,
  parameter int HIST_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PC_W-1:0]   lookup_pc_i,
  output logic              pred_taken_o,
  output logic [HIST_W-1:0] pred_hist_o,
  input  logic              spec_valid_i,
  input  logic [PC_W-1:0]   spec_pc_i,
  input  logic              spec_taken_i,
  input  logic              commit_valid_i,
  input  logic [HIST_W-1:0] commit_hist_i,
  input  logic              commit_taken_i
);
  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic             unused_pc;

  assign rd_idx    = lookup_pc_i[IDX_LSB +: IDX_W];
  assign wr_idx    = spec_pc_i[IDX_LSB +: IDX_W];
  assign unused_pc = ^{lookup_pc_i, spec_pc_i};

  lhist_hist_table #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_hist (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_idx_i (rd_idx),
    .rd_hist_o(pred_hist_o),
    .we_i     (spec_valid_i),
    .wr_idx_i (wr_idx),
    .taken_i  (spec_taken_i)
  );

  lhist_pattern_table #(.HIST_W(HIST_W)) u_pat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_hist_i  (pred_hist_o),
    .rd_taken_o (pred_taken_o),
    .upd_i      (commit_valid_i),
    .upd_hist_i (commit_hist_i),
    .upd_taken_i(commit_taken_i)
  );

  a_r8_no_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spec_valid_i && wr_idx == rd_idx) |-> pred_hist_o == u_hist.mem_q[rd_idx]);
endmodule

// File: tb/lhist_predictor_test.sv
module lhist_predictor_test;
  localparam int PC_W = 16, IDX_LSB = 2, IDX_W = 4, HW = 4;
  localparam int NE = 1 << IDX_W, NC = 1 << HW;

  logic clk = 0, rst_n = 0;
  logic [PC_W-1:0] lpc = '0, spc = '0;
  logic sv = 0, st = 0, cv = 0, ct = 0;
  logic [HW-1:0] ch = '0;
  logic pt;
  logic [HW-1:0] ph;

  int n_tests = 0, n_fail = 0;
  logic [HW-1:0] hist_m [NE];
  int ctr_m [NC];

  always #10 clk = ~clk;

  lhist_predictor #(.PC_W(PC_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W), .HIST_W(HW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .lookup_pc_i(lpc), .pred_taken_o(pt), .pred_hist_o(ph),
    .spec_valid_i(sv), .spec_pc_i(spc), .spec_taken_i(st),
    .commit_valid_i(cv), .commit_hist_i(ch), .commit_taken_i(ct));

  function automatic int idx_of(input logic [PC_W-1:0] pc);
    return int'((pc >> IDX_LSB) & (NE - 1));
  endfunction

  function automatic logic [PC_W-1:0] pc_of(input int i, input int hi);
    return PC_W'((hi << (IDX_LSB + IDX_W)) | (i << IDX_LSB) | (hi & 3));
  endfunction

  task automatic check(input string tag);
    logic [HW-1:0] eh;
    logic et;
    eh = hist_m[idx_of(lpc)];
    et = ctr_m[eh] >= 2;
    n_tests++;
    if (ph !== eh) begin
      n_fail++;
      $display("FAIL %s hist pc=%h actual=%h expected=%h", tag, lpc, ph, eh);
    end
    n_tests++;
    if (pt !== et) begin
      n_fail++;
      $display("FAIL %s pred pc=%h actual=%b expected=%b", tag, lpc, pt, et);
    end
  endtask

  task automatic step(input logic [PC_W-1:0] l, input logic s_v, input logic [PC_W-1:0] s_pc,
                      input logic s_t, input logic c_v, input logic [HW-1:0] c_h,
                      input logic c_t, input string tag);
    lpc = l; sv = s_v; spc = s_pc; st = s_t; cv = c_v; ch = c_h; ct = c_t;
    #2 check(tag);
    @(posedge clk);
    if (c_v) ctr_m[c_h] = c_t ? (ctr_m[c_h] == 3 ? 3 : ctr_m[c_h] + 1)
                              : (ctr_m[c_h] == 0 ? 0 : ctr_m[c_h] - 1);
    if (s_v) hist_m[idx_of(s_pc)] = {hist_m[idx_of(s_pc)][HW-2:0], s_t};
    @(negedge clk);
    sv = 0; cv = 0;
  endtask

  task automatic look(input logic [PC_W-1:0] l, input string tag);
    lpc = l;
    #2 check(tag);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NE; i++) hist_m[i] = '0;
    for (int i = 0; i < NC; i++) ctr_m[i] = 1;
    #45 rst_n = 1;
    @(negedge clk);

    // R1: reset state at every entry
    for (int i = 0; i < NE; i++) look(pc_of(i, i), "R1");

    // R4: entry 0 becomes 0101 (newest at bit 0)
    step(pc_of(0, 0), 1, pc_of(0, 0), 0, 0, 0, 0, "R4");
    step(pc_of(0, 0), 1, pc_of(0, 0), 1, 0, 0, 0, "R8");
    step(pc_of(0, 0), 1, pc_of(0, 0), 0, 0, 0, 0, "R8");
    step(pc_of(0, 0), 1, pc_of(0, 0), 1, 0, 0, 0, "R8");
    look(pc_of(0, 0), "R4");
    n_tests++;
    if (ph !== 4'b0101) begin
      n_fail++;
      $display("FAIL R4 actual=%b expected=0101", ph);
    end

    // R2: alias above slice, neighbours unaffected
    look(pc_of(0, 5), "R2");
    look(pc_of(1, 0), "R2");
    look(pc_of(NE - 1, 0), "R2");

    // R7: train counter 3 while entry 0 holds 5; entry 0 prediction unmoved
    for (int k = 0; k < 3; k++) step(pc_of(0, 0), 0, '0, 0, 1, 4'd3, 1, "R7");
    look(pc_of(0, 0), "R7");
    n_tests++;
    if (pt !== 1'b0) begin
      n_fail++;
      $display("FAIL R7 actual=%b expected=0", pt);
    end

    // R6: saturate counter 5 high then walk it down past 0
    for (int k = 0; k < 5; k++) step(pc_of(0, 0), 0, '0, 0, 1, 4'd5, 1, "R6");
    step(pc_of(0, 0), 0, '0, 0, 1, 4'd5, 0, "R6");
    look(pc_of(0, 0), "R6");
    n_tests++;
    if (pt !== 1'b1) begin
      n_fail++;
      $display("FAIL R6 one step from 3 actual=%b expected=1", pt);
    end
    for (int k = 0; k < 5; k++) step(pc_of(0, 0), 0, '0, 0, 1, 4'd5, 0, "R6");
    step(pc_of(0, 0), 0, '0, 0, 1, 4'd5, 1, "R6");
    look(pc_of(0, 0), "R6");
    n_tests++;
    if (pt !== 1'b0) begin
      n_fail++;
      $display("FAIL R6 one step from 0 actual=%b expected=0", pt);
    end

    // R9/R5/R3: mixed random traffic against the model
    for (int k = 0; k < 4000; k++) begin
      step(PC_W'($urandom), 1'($urandom), PC_W'($urandom), 1'($urandom),
           1'($urandom), HW'($urandom), 1'($urandom), "R9");
    end
    for (int i = 0; i < NE; i++) look(pc_of(i, 0), "R5");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule